// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block turns one host request into the series of per-byte commands that a byte-level I2C master engine needs. A request carries a 7-bit target address, a write byte count, a read byte count, and two flags: one that asks for a start condition at the beginning and one that asks for a stop condition at the end. Write bytes come in on a ready/valid stream and are consumed one per write command. Read bytes come back from the engine and leave on a second ready/valid stream. The block runs the write phase first, then the read phase, and puts a repeated start on the direction change.

For every byte the sequencer presents a 4-bit command word and the address byte to the engine, then waits for the engine's done pulse. It checks the engine's error status after each byte and aborts on a fault. The one exception is a byte that carried a start bit: its status is ignored. An abort, or a transaction that runs past its time limit, issues a stop-only command. The block then waits a fixed recovery interval before it reports completion. If a start-flagged request arrives while the engine reports a stale clock-timeout or lost-arbitration condition, the block first resets the engine and waits the same recovery interval. Both the interval and the time limit are parameters counted in clock cycles.

Top module: `i2c_xfer_seq`

## Requirements
- R1: Command word bits are RUN=bit0, START=bit1, STOP=bit2, ACK=bit3. For a write phase that ends the transaction (stop flag set, read count 0), the commands are 0x3, then 0x1 for each middle byte, then 0x5 for the last byte. A single such write byte gets 0x7.
- R2: A read phase with the stop flag set issues 0xB, then 0x9 for each middle byte, then 0x5 for the last byte. A single such read byte gets 0x7. Without the stop flag the last read byte gets ACK (bit3) instead of STOP.
- R3: START is set only on the first byte of a phase. In the write phase it is set only when the start flag is set. The first read byte after a write phase always carries START (repeated start).
- R4: STOP is attached to the last write byte only when the stop flag is set and the read count is zero.
- R5: The engine address byte is {addr, 0} during the write phase and {addr, 1} during the read phase.
- R6: A clkto, arblost or buserr status at the done of a byte issued without START aborts the transaction. The block issues the command 0x4 and then waits at least IDLE_CYC cycles. It then reports done with error code 1. Status at the done of a byte that carried START is ignored.
- R7: A transaction still waiting TIMEOUT_CYC cycles after acceptance is aborted. The block issues 0x4, waits at least IDLE_CYC cycles, and reports done with error code 2.
- R8: A request with both counts zero completes in the cycle after acceptance with error code 0, and no command is issued.
- R9: A start-flagged, non-empty request that finds clkto or arblost set pulses eng_reset for one cycle. The first command then follows at least IDLE_CYC cycles later.
- R10: req_ready is high only when the block is idle. A request offered while busy is ignored. done is a one-cycle pulse, and err_code is 0 on success.
- R11: Read bytes leave in engine order and are held stable under rd_ready backpressure. A write byte is consumed only in the cycle its write command is issued.
- R12: After reset the block is idle: req_ready=1, and done, eng_cmd_valid, eng_reset, wr_ready and rd_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request accepted |
| req_addr | input | 7 | Target address |
| req_wr_cnt | input | CNT_W | Bytes to write |
| req_rd_cnt | input | CNT_W | Bytes to read |
| req_start | input | 1 | Begin with a start condition |
| req_stop | input | 1 | End with a stop condition |
| wr_valid | input | 1 | Write byte available |
| wr_ready | output | 1 | Write byte consumed |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Host takes read byte |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Transaction finished (one cycle) |
| err_code | output | 2 | 0 success, 1 bus fault, 2 timeout |
| eng_cmd_valid | output | 1 | Command presented to engine |
| eng_cmd | output | 4 | Command word |
| eng_addr | output | 8 | Address byte with direction bit |
| eng_wdata | output | 8 | Byte to transmit |
| eng_reset | output | 1 | Engine reset pulse |
| eng_done | input | 1 | Engine finished a byte |
| eng_rdata | input | 8 | Received byte |
| eng_clkto | input | 1 | Engine clock-timeout status |
| eng_arblost | input | 1 | Engine lost-arbitration status |
| eng_buserr | input | 1 | Engine bus error status |

## Verification
The bench goes after the command codes at the phase edges: single-byte phases, write-then-read, and a read without stop followed by a continuation without start. A design that placed STOP before a read phase, or dropped the repeated start, would show the wrong code in the scoreboard. It injects a fault on a start-carrying byte, which must pass, and on a middle byte, which must end in 0x4 followed by a timed quiet gap. A design that skipped the start exemption would abort a good transfer, and one that skipped the recovery wait would report done too early. Starving the write stream exercises the time limit. A stale arbitration status exercises the reset-then-wait path. Read backpressure and a stray request during a busy transfer show whether data is lost or a second transaction slips in.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
   localparam int CMD_W = 4;
   localparam logic [CMD_W-1:0] CMD_RUN   = 4'h1;
   localparam logic [CMD_W-1:0] CMD_START = 4'h2;
   localparam logic [CMD_W-1:0] CMD_STOP  = 4'h4;
   localparam logic [CMD_W-1:0] CMD_ACK   = 4'h8;

   localparam logic [1:0] ERR_NONE    = 2'd0;
   localparam logic [1:0] ERR_BUS     = 2'd1;
   localparam logic [1:0] ERR_TIMEOUT = 2'd2;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RSTW, ST_NEXT, ST_WAIT, ST_PUSH, ST_ABORT, ST_RECOV, ST_FIN
   } seq_state_t;
endpackage

// File: rtl/i2c_seq_cmdgen.sv
module i2c_seq_cmdgen
   import i2c_seq_pkg::*;
(
   input  logic             rd_phase,
   input  logic             start_pend,
   input  logic             last_byte,
   input  logic             stop_flag,
   input  logic             rd_none,
   output logic [CMD_W-1:0] cmd
);
   always_comb begin
      cmd = CMD_RUN;
      if (start_pend) cmd = cmd | CMD_START;
      if (rd_phase) begin
         if (last_byte && stop_flag) cmd = cmd | CMD_STOP;
         else                        cmd = cmd | CMD_ACK;
      end else if (last_byte && stop_flag && rd_none) begin
         cmd = cmd | CMD_STOP;
      end
   end
endmodule

// File: rtl/i2c_seq_timer.sv
module i2c_seq_timer #(
   parameter int MAX_CNT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic expired
);
   localparam int TW = (MAX_CNT < 1) ? 1 : $clog2(MAX_CNT + 1);

   generate
      if (MAX_CNT == 0) begin : g_none
         logic unused_in;
         assign unused_in = load ^ clk ^ rst_n;
         assign expired   = 1'b1;
      end else begin : g_cnt
         logic [TW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (load)        cnt <= TW'(MAX_CNT);
            else if (cnt != '0)   cnt <= cnt - TW'(1);
         end
         assign expired = (cnt == '0);
      end
   endgenerate
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
   import i2c_seq_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int IDLE_CYC    = 50000,
   parameter int TIMEOUT_CYC = 100000000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [6:0]       req_addr,
   input  logic [CNT_W-1:0] req_wr_cnt,
   input  logic [CNT_W-1:0] req_rd_cnt,
   input  logic             req_start,
   input  logic             req_stop,
   input  logic             wr_valid,
   output logic             wr_ready,
   input  logic [7:0]       wr_data,
   output logic             rd_valid,
   input  logic             rd_ready,
   output logic [7:0]       rd_data,
   output logic             done,
   output logic [1:0]       err_code,
   output logic             eng_cmd_valid,
   output logic [3:0]       eng_cmd,
   output logic [7:0]       eng_addr,
   output logic [7:0]       eng_wdata,
   output logic             eng_reset,
   input  logic             eng_done,
   input  logic [7:0]       eng_rdata,
   input  logic             eng_clkto,
   input  logic             eng_arblost,
   input  logic             eng_buserr
);
   generate
      if (CNT_W < 1)                begin : g_bad_cnt  $error("CNT_W must be at least 1"); end
      if (IDLE_CYC < 1)             begin : g_bad_idle $error("IDLE_CYC must be at least 1"); end
      if (TIMEOUT_CYC <= IDLE_CYC)  begin : g_bad_tmo  $error("TIMEOUT_CYC must exceed IDLE_CYC"); end
   endgenerate

   seq_state_t       state;
   logic [6:0]       addr_q;
   logic [CNT_W-1:0] wr_cnt_q, rd_cnt_q, idx, phase_cnt;
   logic             stop_q, rd_phase, start_pend, cur_start;
   logic [7:0]       rd_data_q;
   logic [1:0]       err_q;
   logic             rst_q;
   logic             last_byte, timeout_hit, cmd_fire, go_rst, req_empty;
   logic             idle_load, idle_exp, tmo_exp;
   logic [CMD_W-1:0] gen_cmd;

   assign req_empty   = (req_wr_cnt == '0) && (req_rd_cnt == '0);
   assign go_rst      = (state == ST_IDLE) && req_valid && !req_empty &&
                        req_start && (eng_clkto || eng_arblost);
   assign idle_load   = go_rst || (state == ST_ABORT);
   assign phase_cnt   = rd_phase ? rd_cnt_q : wr_cnt_q;
   assign last_byte   = (idx == phase_cnt - CNT_W'(1));
   assign timeout_hit = tmo_exp && ((state == ST_NEXT) || (state == ST_WAIT) ||
                                    (state == ST_PUSH));
   assign cmd_fire    = (state == ST_NEXT) && !timeout_hit && (rd_phase || wr_valid);

   i2c_seq_timer #(.MAX_CNT(IDLE_CYC)) u_idle_tmr (
      .clk(clk), .rst_n(rst_n), .load(idle_load), .expired(idle_exp));

   i2c_seq_timer #(.MAX_CNT(TIMEOUT_CYC)) u_xfer_tmr (
      .clk(clk), .rst_n(rst_n), .load((state == ST_IDLE) && req_valid),
      .expired(tmo_exp));

   i2c_seq_cmdgen u_cmdgen (
      .rd_phase(rd_phase), .start_pend(start_pend), .last_byte(last_byte),
      .stop_flag(stop_q), .rd_none(rd_cnt_q == '0), .cmd(gen_cmd));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         addr_q     <= '0;
         wr_cnt_q   <= '0;
         rd_cnt_q   <= '0;
         idx        <= '0;
         stop_q     <= 1'b0;
         rd_phase   <= 1'b0;
         start_pend <= 1'b0;
         cur_start  <= 1'b0;
         rd_data_q  <= '0;
         err_q      <= ERR_NONE;
         rst_q      <= 1'b0;
      end else begin
         rst_q <= 1'b0;
         case (state)
            ST_IDLE: if (req_valid) begin
               addr_q     <= req_addr;
               wr_cnt_q   <= req_wr_cnt;
               rd_cnt_q   <= req_rd_cnt;
               stop_q     <= req_stop;
               start_pend <= req_start;
               rd_phase   <= (req_wr_cnt == '0);
               idx        <= '0;
               err_q      <= ERR_NONE;
               if (req_empty)   state <= ST_FIN;
               else if (go_rst) begin
                  rst_q <= 1'b1;
                  state <= ST_RSTW;
               end else         state <= ST_NEXT;
            end
            ST_RSTW: if (idle_exp) state <= ST_NEXT;
            ST_NEXT: begin
               if (timeout_hit) begin
                  err_q <= ERR_TIMEOUT;
                  state <= ST_ABORT;
               end else if (cmd_fire) begin
                  cur_start  <= start_pend;
                  start_pend <= 1'b0;
                  state      <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (timeout_hit) begin
                  err_q <= ERR_TIMEOUT;
                  state <= ST_ABORT;
               end else if (eng_done) begin
                  if ((eng_clkto || eng_arblost || eng_buserr) && !cur_start) begin
                     err_q <= ERR_BUS;
                     state <= ST_ABORT;
                  end else if (rd_phase) begin
                     rd_data_q <= eng_rdata;
                     state     <= ST_PUSH;
                  end else if (!last_byte) begin
                     idx   <= idx + CNT_W'(1);
                     state <= ST_NEXT;
                  end else if (rd_cnt_q != '0) begin
                     rd_phase   <= 1'b1;
                     idx        <= '0;
                     start_pend <= 1'b1;
                     state      <= ST_NEXT;
                  end else begin
                     state <= ST_FIN;
                  end
               end
            end
            ST_PUSH: begin
               if (timeout_hit) begin
                  err_q <= ERR_TIMEOUT;
                  state <= ST_ABORT;
               end else if (rd_ready) begin
                  if (last_byte) state <= ST_FIN;
                  else begin
                     idx   <= idx + CNT_W'(1);
                     state <= ST_NEXT;
                  end
               end
            end
            ST_ABORT: state <= ST_RECOV;
            ST_RECOV: if (idle_exp) state <= ST_FIN;
            ST_FIN:   state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready     = (state == ST_IDLE);
   assign wr_ready      = cmd_fire && !rd_phase;
   assign eng_cmd_valid = cmd_fire || (state == ST_ABORT);
   assign eng_cmd       = (state == ST_ABORT) ? CMD_STOP : gen_cmd;
   assign eng_addr      = {addr_q, rd_phase};
   assign eng_wdata     = wr_data;
   assign eng_reset     = rst_q;
   assign rd_valid      = (state == ST_PUSH);
   assign rd_data       = rd_data_q;
   assign done          = (state == ST_FIN);
   assign err_code      = err_q;
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk #(
   parameter int IDLE_CYC = 50000
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_ready,
   input logic       done,
   input logic [1:0] err_code,
   input logic       eng_cmd_valid,
   input logic [3:0] eng_cmd,
   input logic [7:0] eng_addr,
   input logic       eng_reset,
   input logic       wr_valid,
   input logic       wr_ready,
   input logic       rd_valid,
   input logic       rd_ready,
   input logic [7:0] rd_data
);
   localparam int GW = $clog2(IDLE_CYC + 1);
   logic [GW-1:0] gap_stop, gap_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_stop <= '0;
         gap_rst  <= '0;
      end else begin
         if (eng_cmd_valid && eng_cmd == 4'h4) gap_stop <= GW'(IDLE_CYC);
         else if (gap_stop != '0)              gap_stop <= gap_stop - GW'(1);
         if (eng_reset)                        gap_rst  <= GW'(IDLE_CYC);
         else if (gap_rst != '0)               gap_rst  <= gap_rst - GW'(1);
      end
   end

   p_cmd_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid |-> (eng_cmd[0] || eng_cmd == 4'h4));
   p_stop_ack_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid |-> !(eng_cmd[2] && eng_cmd[3]));
   p_ack_read_dir_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_cmd_valid && eng_cmd[3]) |-> eng_addr[0]);
   p_idle_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (gap_stop == '0));
   p_reset_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid |-> (gap_rst == '0));
   p_reset_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      eng_reset |=> !eng_reset);
   p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
      eng_cmd_valid |-> !req_ready);
   p_err_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (err_code != 2'd3));
   p_wr_take_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_ready) |-> (eng_cmd_valid && !eng_addr[0]));
   p_rd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> ((rd_valid && $stable(rd_data)) ||
                                   (eng_cmd_valid && eng_cmd == 4'h4)));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk #(.IDLE_CYC(IDLE_CYC)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
   .err_code(err_code), .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd),
   .eng_addr(eng_addr), .eng_reset(eng_reset), .wr_valid(wr_valid),
   .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_ready(rd_ready),
   .rd_data(rd_data));

// File: tb/i2c_xfer_seq_tb_top.sv
`timescale 1ns/100ps
module i2c_xfer_seq_tb_top;
   localparam int CNT_W = 8;
   localparam int IDLE  = 20;
   localparam int TMO   = 300;
   localparam int LAT   = 3;

   typedef struct packed {
      logic       chk_addr;
      logic       chk_data;
      logic [7:0] addr;
      logic [3:0] cmd;
      logic [7:0] data;
   } item_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [6:0] req_addr = '0;
   logic [CNT_W-1:0] req_wr_cnt = '0, req_rd_cnt = '0;
   logic req_start = 1'b0, req_stop = 1'b0;
   logic wr_valid = 1'b0, wr_ready;
   logic [7:0] wr_data = '0;
   logic rd_valid, rd_ready = 1'b1;
   logic [7:0] rd_data;
   logic done;
   logic [1:0] err_code;
   logic eng_cmd_valid, eng_reset;
   logic [3:0] eng_cmd;
   logic [7:0] eng_addr, eng_wdata;
   logic eng_done = 1'b0, eng_clkto = 1'b0, eng_arblost = 1'b0, eng_buserr = 1'b0;
   logic [7:0] eng_rdata = '0;

   always #2.5 clk = ~clk;

   i2c_xfer_seq #(.CNT_W(CNT_W), .IDLE_CYC(IDLE), .TIMEOUT_CYC(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_wr_cnt(req_wr_cnt), .req_rd_cnt(req_rd_cnt),
      .req_start(req_start), .req_stop(req_stop), .wr_valid(wr_valid),
      .wr_ready(wr_ready), .wr_data(wr_data), .rd_valid(rd_valid),
      .rd_ready(rd_ready), .rd_data(rd_data), .done(done), .err_code(err_code),
      .eng_cmd_valid(eng_cmd_valid), .eng_cmd(eng_cmd), .eng_addr(eng_addr),
      .eng_wdata(eng_wdata), .eng_reset(eng_reset), .eng_done(eng_done),
      .eng_rdata(eng_rdata), .eng_clkto(eng_clkto), .eng_arblost(eng_arblost),
      .eng_buserr(eng_buserr));

   int nchk = 0, nfail = 0, cyc = 0;
   item_t exp_cmd[$];
   logic [7:0] exp_rd[$];
   logic [7:0] wr_q[$];
   int exp_code = 0, ndone = 0, nreset = 0;
   int done_cyc = 0, stop_cyc = 0, rst_cyc = 0;
   bit done_seen = 0, rst_pend = 0, rd_bp = 0, wr_hs = 0;
   string cur_tag = "R12";
   int err_at = -1, eng_cmd_idx = 0, eng_rd_idx = 0, pend = 0, cur_idx = 0;
   bit cur_rd = 0;

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == 60000) begin
         nfail++;
         $display("FAIL watchdog actual=%0d expected=<60000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   // write stream source and read backpressure, updated just after the edge
   always @(posedge clk) begin
      #1;
      if (wr_hs && wr_q.size() > 0) void'(wr_q.pop_front());
      wr_valid = (wr_q.size() > 0);
      wr_data  = (wr_q.size() > 0) ? wr_q[0] : 8'h00;
      rd_ready = rd_bp ? ~rd_ready : 1'b1;
   end

   // byte engine model
   always @(negedge clk) begin
      eng_done   = 1'b0;
      eng_buserr = 1'b0;
      if (pend > 0) begin
         pend--;
         if (pend == 0) begin
            eng_done = 1'b1;
            if (cur_rd) begin
               eng_rdata = 8'h5A + 8'(3 * eng_rd_idx);
               eng_rd_idx++;
            end
            if (cur_idx == err_at) eng_buserr = 1'b1;
         end
      end
      if (eng_cmd_valid && eng_cmd != 4'h4) begin
         pend    = LAT;
         cur_idx = eng_cmd_idx;
         cur_rd  = eng_addr[0];
         eng_cmd_idx++;
      end
      if (eng_reset) eng_arblost = 1'b0;
   end

   // scoreboard monitor
   always @(negedge clk) begin
      wr_hs = wr_valid && wr_ready;
      if (rst_n) begin
         if (eng_cmd_valid) begin
            if (exp_cmd.size() == 0) begin
               chk(1'b0, cur_tag, "unexpected command", eng_cmd, 0);
            end else begin
               item_t e;
               e = exp_cmd.pop_front();
               chk(eng_cmd == e.cmd, cur_tag, "command word", eng_cmd, e.cmd);
               if (e.chk_addr)
                  chk(eng_addr == e.addr, {cur_tag, " R5"}, "address byte", eng_addr, e.addr);
               if (e.chk_data)
                  chk(eng_wdata == e.data, {cur_tag, " R11"}, "write byte", eng_wdata, e.data);
            end
            if (eng_cmd == 4'h4) stop_cyc = cyc;
            if (rst_pend) begin
               chk(cyc - rst_cyc >= IDLE, "R9", "reset-to-command gap", cyc - rst_cyc, IDLE);
               rst_pend = 0;
            end
         end
         if (eng_reset) begin
            rst_cyc  = cyc;
            rst_pend = 1;
            nreset++;
         end
         if (rd_valid && rd_ready) begin
            if (exp_rd.size() == 0) chk(1'b0, "R11", "unexpected read byte", rd_data, 0);
            else begin
               logic [7:0] b;
               b = exp_rd.pop_front();
               chk(rd_data == b, "R11", "read byte", rd_data, b);
            end
         end
         if (done) begin
            done_seen = 1;
            done_cyc  = cyc;
            ndone++;
            chk(err_code == 2'(exp_code), {cur_tag, " R10"}, "error code", err_code, exp_code);
            if (err_code != 2'd0)
               chk(cyc - stop_cyc >= IDLE, "R6 R7", "stop-to-done gap", cyc - stop_cyc, IDLE);
         end
      end
   end

   // driver: builds expectations, then issues one request
   task automatic txn(input string tag, input logic [6:0] a, input int wc, input int rc,
                      input bit st, input bit sp, input int inj, input int keep,
                      input int supply, input int code, input bit stray);
      item_t lst[$];
      item_t it;
      int acc;
      for (int i = 0; i < wc; i++) begin
         it.chk_addr = 1'b1; it.chk_data = 1'b1;
         it.addr = {a, 1'b0};
         it.data = 8'hC0 + 8'(i) + 8'(wc * 16);
         it.cmd  = 4'h1 | ((i == 0 && st) ? 4'h2 : 4'h0) |
                   ((i == wc - 1 && sp && rc == 0) ? 4'h4 : 4'h0);
         lst.push_back(it);
      end
      for (int j = 0; j < rc; j++) begin
         it.chk_addr = 1'b1; it.chk_data = 1'b0;
         it.addr = {a, 1'b1};
         it.data = 8'h00;
         it.cmd  = 4'h1 | ((j == 0 && (st || wc > 0)) ? 4'h2 : 4'h0) |
                   ((j == rc - 1 && sp) ? 4'h4 : 4'h8);
         lst.push_back(it);
      end
      @(posedge clk); #2;
      cur_tag = tag;
      exp_code = code;
      err_at = inj;
      eng_cmd_idx = 0;
      eng_rd_idx = 0;
      wr_q.delete();
      for (int i = 0; i < supply; i++) wr_q.push_back(8'hC0 + 8'(i) + 8'(wc * 16));
      if (keep < 0) begin
         foreach (lst[k]) exp_cmd.push_back(lst[k]);
         for (int j = 0; j < rc; j++) exp_rd.push_back(8'h5A + 8'(3 * j));
      end else begin
         for (int k = 0; k < keep; k++) exp_cmd.push_back(lst[k]);
         it.chk_addr = 1'b0; it.chk_data = 1'b0; it.addr = 8'h00;
         it.cmd = 4'h4; it.data = 8'h00;
         exp_cmd.push_back(it);
      end
      @(posedge clk); #2;
      chk(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
      req_addr = a; req_wr_cnt = CNT_W'(wc); req_rd_cnt = CNT_W'(rc);
      req_start = st; req_stop = sp; req_valid = 1'b1;
      acc = cyc;
      @(posedge clk); #2;
      req_valid = 1'b0;
      if (stray) begin
         @(posedge clk); #2;
         chk(req_ready == 1'b0, "R10", "ready while busy", req_ready, 0);
         req_addr = 7'h11; req_wr_cnt = 8'd1; req_rd_cnt = 8'd0;
         req_start = 1'b1; req_stop = 1'b1; req_valid = 1'b1;
         @(posedge clk); #2;
         req_valid = 1'b0;
      end
      while (!done_seen) @(negedge clk);
      done_seen = 0;
      chk(exp_cmd.size() == 0, tag, "commands left unissued", exp_cmd.size(), 0);
      chk(exp_rd.size() == 0, "R11", "read bytes not delivered", exp_rd.size(), 0);
      if (wc == 0 && rc == 0)
         chk(done_cyc == acc + 1, "R8", "done latency", done_cyc - acc, 1);
      if (code == 2)
         chk(done_cyc - acc >= TMO, "R7", "timeout latency", done_cyc - acc, TMO);
      exp_cmd.delete();
      exp_rd.delete();
      repeat (4) @(posedge clk);
   endtask

   initial begin
      int nd, nr;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(req_ready == 1'b1, "R12", "req_ready in reset", req_ready, 1);
      chk(done == 1'b0 && eng_cmd_valid == 1'b0 && eng_reset == 1'b0, "R12",
          "outputs in reset", {done, eng_cmd_valid, eng_reset}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_ready == 1'b0 && rd_valid == 1'b0 && req_ready == 1'b1, "R12",
          "idle after reset", {wr_ready, rd_valid, req_ready}, 3'b001);

      // multi-byte write 0x3 0x1 0x5
      txn("R1 R3 R4", 7'h2A, 3, 0, 1, 1, -1, -1, 3, 0, 0);
      // single write 0x7
      txn("R1", 7'h15, 1, 0, 1, 1, -1, -1, 1, 0, 0);
      // multi-byte read 0xB 0x9 0x5
      txn("R2", 7'h33, 0, 3, 1, 1, -1, -1, 0, 0, 0);
      // single read 0x7
      txn("R2", 7'h40, 0, 1, 1, 1, -1, -1, 0, 0, 0);
      // write then read with repeated start, stray request while busy
      nd = ndone;
      txn("R3 R4 R10", 7'h50, 2, 2, 1, 1, -1, -1, 2, 0, 1);
      repeat (30) @(posedge clk);
      chk(ndone == nd + 1, "R10", "done count after stray request", ndone - nd, 1);
      // read without stop, last byte ACKed; continuation without start
      txn("R2 R3", 7'h61, 0, 2, 1, 0, -1, -1, 0, 0, 0);
      txn("R2 R3", 7'h61, 0, 1, 0, 1, -1, -1, 0, 0, 0);
      // write without start flag: 0x1 0x5
      txn("R3", 7'h0F, 2, 0, 0, 1, -1, -1, 2, 0, 0);
      // empty request
      txn("R8", 7'h01, 0, 0, 1, 1, -1, -1, 0, 0, 0);
      // bus fault on middle byte: 0x3 0x1 then 0x4
      txn("R6", 7'h22, 3, 0, 1, 1, 1, 2, 3, 1, 0);
      // bus fault on start byte is ignored
      txn("R6", 7'h23, 2, 0, 1, 1, 0, -1, 2, 0, 0);
      // starved write stream times out
      txn("R7", 7'h24, 3, 0, 1, 1, -1, 1, 1, 2, 0);
      // stale arbitration status forces an engine reset first
      nr = nreset;
      @(posedge clk); #2;
      eng_arblost = 1'b1;
      txn("R9", 7'h35, 1, 0, 1, 1, -1, -1, 1, 0, 0);
      chk(nreset == nr + 1, "R9", "engine reset pulses", nreset - nr, 1);
      // read under backpressure
      rd_bp = 1;
      txn("R2 R11", 7'h36, 0, 4, 1, 1, -1, -1, 0, 0, 0);
      rd_bp = 0;

      repeat (5) @(posedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule